// File: doc/BRIEF.md
# AES-128 Byte-Serial Key Schedule Builder

This block turns a 128-bit cipher key into the complete AES-128 round-key schedule of 176 bytes (44 words of 4 bytes). It works one byte at a time and writes each result byte into an external synchronous key RAM. The cipher rounds then read that RAM. The non-linear step of the schedule (the byte substitution applied to every fourth word) does not use a local table. Instead the block reads a shared synchronous 512-byte substitution ROM. The forward table sits at addresses 0 to 255 and the inverse table at addresses 256 to 511. Only the forward half is used here.

A user drives the key on `keyIn` and pulses `start` while the block is idle. The key is captured on that edge. The block writes the raw key bytes first, then builds each derived word from a four-word sliding window that it holds in registers. A one-cycle `done` pulse marks the end of the run. The 16 key bytes are ordered most significant byte first: schedule byte 0 is `keyIn[127:120]`, and word w[k] is made of bytes 4k to 4k+3.

Top module: `keySchedExpand`

## Requirements
- R1: After reset, `busy`, `done` and `ramWe` are low, and no RAM write happens until a start is accepted.
- R2: A `start` pulse while `busy` is low is accepted. `busy` is high in the following cycle and stays high until the run ends.
- R3: `keyIn` is captured when the start is accepted. RAM bytes 0..15 receive the captured key, with byte n equal to `keyIn[127-8n -: 8]`. Later changes to `keyIn` do not affect the run.
- R4: For a word index k from 4 to 43 that is not a multiple of 4, w[k] = w[k-4] XOR w[k-1].
- R5: For a word index k that is a multiple of 4, w[k] = w[k-4] XOR SubWord(RotWord(w[k-1])) XOR {rc, 0, 0, 0}. RotWord moves the top byte to the bottom. The round constant rc takes the values 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36 in turn.
- R6: Substitutions are read from `romAddr` with bit 8 clear, so only the forward table is used. The ROM data is taken one cycle after the address is presented.
- R7: Each run makes exactly 176 RAM writes, at addresses 0, 1, ..., 175 in ascending order, each written once.
- R8: `done` is high for exactly one cycle. That cycle comes directly after the cycle that writes byte 175, and `busy` falls in the following cycle.
- R9: A `start` pulse while `busy` is high is ignored. The run in progress completes with its original key, and no extra writes occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to expand the key on `keyIn` |
| keyIn | input | 128 | Cipher key, byte 0 in bits 127:120 |
| busy | output | 1 | Expansion in progress |
| done | output | 1 | One-cycle completion pulse |
| romAddr | output | 9 | Substitution ROM address |
| romData | input | 8 | Substitution ROM data, valid one cycle after the address |
| ramWe | output | 1 | Key RAM write strobe |
| ramAddr | output | 8 | Key RAM byte address |
| ramWdata | output | 8 | Key RAM write data |

## Verification
The assertions assume a ROM that returns the addressed byte exactly one cycle later. They also assume that `start` is a synchronous level sampled on rising edges, and that the key checked against the first 16 written bytes is the one present on the accepting edge. The bench meets these assumptions by modelling the ROM as a registered table computed in the bench from the field arithmetic. It drives `start` and `keyIn` only on falling edges. When it tests the ignore rule, it changes `keyIn` only after the start has been accepted.

// File: rtl/keySchedPkg.sv
package keySchedPkg;
  localparam int KEY_BYTES   = 16;
  localparam int WORD_BYTES  = 4;
  localparam int KEY_WORDS   = KEY_BYTES / WORD_BYTES;
  localparam int ROUNDS      = 10;
  localparam int TOTAL_WORDS = KEY_WORDS * (ROUNDS + 1);
  localparam int TOTAL_BYTES = TOTAL_WORDS * WORD_BYTES;
  localparam int ADDR_W      = $clog2(TOTAL_BYTES);
  localparam int WIDX_W      = $clog2(TOTAL_WORDS);
  localparam int ROM_ADDR_W  = 9;
  localparam logic [7:0] RCON_FIRST = 8'h01;

  typedef struct packed {
    logic       loadKey;
    logic       subCap;
    logic       latchWord;
    logic       useSub;
    logic       shiftWin;
    logic       wrFromKey;
    logic [3:0] lane;
  } ctrlT;
endpackage

// File: rtl/keySchedPath.sv
module keySchedPath
  import keySchedPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlT                  ctl,
  input  logic [127:0]          keyIn,
  input  logic [7:0]            romData,
  output logic [ROM_ADDR_W-1:0] romAddr,
  output logic [7:0]            wrByte
);
  logic [127:0] window;
  logic [31:0]  newWord;
  logic [7:0]   rcon;
  logic [7:0]   subByte [WORD_BYTES];
  logic [31:0]  prevWord, rotWord, subWord;
  int           laneW, laneK;

  assign prevWord = window[31:0];
  assign rotWord  = {prevWord[23:0], prevWord[31:24]};
  assign laneW    = int'(ctl.lane[1:0]);
  assign laneK    = int'(ctl.lane);
  assign subWord  = {subByte[0], subByte[1], subByte[2], subByte[3]};

  assign romAddr = {1'b0, rotWord[8*(3-laneW) +: 8]};
  assign wrByte  = ctl.wrFromKey ? window[8*(15-laneK) +: 8]
                                 : newWord[8*(3-laneW) +: 8];

  for (genvar g = 0; g < WORD_BYTES; g++) begin : gSub
    always_ff @(posedge clk) begin
      if (!rstN)
        subByte[g] <= '0;
      else if (ctl.subCap && ctl.lane[1:0] == 2'(g))
        subByte[g] <= romData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      window  <= '0;
      newWord <= '0;
      rcon    <= RCON_FIRST;
    end else begin
      if (ctl.loadKey) begin
        window <= keyIn;
        rcon   <= RCON_FIRST;
      end
      if (ctl.latchWord) begin
        if (ctl.useSub) begin
          newWord <= window[127:96] ^ subWord ^ {rcon, 24'h0};
          rcon    <= {rcon[6:0], 1'b0} ^ (rcon[7] ? 8'h1B : 8'h00);
        end else begin
          newWord <= window[127:96] ^ prevWord;
        end
      end
      if (ctl.shiftWin)
        window <= {window[95:0], newWord};
    end
  end
endmodule

// File: rtl/keySchedCtrl.sv
module keySchedCtrl
  import keySchedPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output ctrlT              ctl,
  output logic              busy,
  output logic              done,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr
);
  typedef enum logic [2:0] {
    S_IDLE, S_KEYWR, S_SUBREQ, S_SUBCAP, S_COMBINE, S_WRWORD, S_DONE
  } stateT;

  stateT             state, stateNx;
  logic [3:0]        cnt, cntNx;
  logic [WIDX_W-1:0] wordIdx, wordIdxNx;
  logic [ADDR_W-1:0] wrAddrNx;

  localparam logic [WIDX_W-1:0] FIRST_DERIVED = WIDX_W'(KEY_WORDS);
  localparam logic [WIDX_W-1:0] LAST_WORD     = WIDX_W'(TOTAL_WORDS - 1);

  always_comb begin
    stateNx   = state;
    cntNx     = cnt;
    wordIdxNx = wordIdx;
    wrAddrNx  = ramAddr;
    ctl       = '0;
    ctl.lane  = cnt;
    ramWe     = 1'b0;
    done      = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          ctl.loadKey = 1'b1;
          cntNx       = '0;
          wrAddrNx    = '0;
          stateNx     = S_KEYWR;
        end
      end
      S_KEYWR: begin
        ramWe         = 1'b1;
        ctl.wrFromKey = 1'b1;
        wrAddrNx      = ramAddr + 1'b1;
        cntNx         = cnt + 1'b1;
        if (cnt == 4'(KEY_BYTES - 1)) begin
          cntNx     = '0;
          wordIdxNx = FIRST_DERIVED;
          stateNx   = S_SUBREQ;
        end
      end
      S_SUBREQ: stateNx = S_SUBCAP;
      S_SUBCAP: begin
        ctl.subCap = 1'b1;
        cntNx      = cnt + 1'b1;
        stateNx    = (cnt == 4'(WORD_BYTES - 1)) ? S_COMBINE : S_SUBREQ;
      end
      S_COMBINE: begin
        ctl.latchWord = 1'b1;
        ctl.useSub    = (wordIdx[1:0] == 2'b00);
        cntNx         = '0;
        stateNx       = S_WRWORD;
      end
      S_WRWORD: begin
        ramWe    = 1'b1;
        wrAddrNx = ramAddr + 1'b1;
        cntNx    = cnt + 1'b1;
        if (cnt == 4'(WORD_BYTES - 1)) begin
          ctl.shiftWin = 1'b1;
          cntNx        = '0;
          if (wordIdx == LAST_WORD) begin
            stateNx = S_DONE;
          end else begin
            wordIdxNx = wordIdx + 1'b1;
            stateNx   = (wordIdxNx[1:0] == 2'b00) ? S_SUBREQ : S_COMBINE;
          end
        end
      end
      S_DONE: begin
        done    = 1'b1;
        stateNx = S_IDLE;
      end
      default: stateNx = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      wordIdx <= '0;
      ramAddr <= '0;
    end else begin
      state   <= stateNx;
      cnt     <= cntNx;
      wordIdx <= wordIdxNx;
      ramAddr <= wrAddrNx;
    end
  end
endmodule

// File: rtl/keySchedExpand.sv
module keySchedExpand
  import keySchedPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [127:0] keyIn,
  output logic         busy,
  output logic         done,
  output logic [8:0]   romAddr,
  input  logic [7:0]   romData,
  output logic         ramWe,
  output logic [7:0]   ramAddr,
  output logic [7:0]   ramWdata
);
  ctrlT ctl;

  keySchedCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .ctl     (ctl),
    .busy    (busy),
    .done    (done),
    .ramWe   (ramWe),
    .ramAddr (ramAddr)
  );

  keySchedPath uPath (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .keyIn   (keyIn),
    .romData (romData),
    .romAddr (romAddr),
    .wrByte  (ramWdata)
  );
endmodule

// File: rtl/keySchedChecker.sv
module keySchedChecker (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic [127:0] keyIn,
  input logic         busy,
  input logic         done,
  input logic [8:0]   romAddr,
  input logic         ramWe,
  input logic [7:0]   ramAddr,
  input logic [7:0]   ramWdata
);
  logic [127:0] keyCap;
  logic         seenWrite;
  logic [7:0]   lastAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyCap    <= '0;
      seenWrite <= 1'b0;
      lastAddr  <= '0;
    end else begin
      if (start && !busy) begin
        keyCap    <= keyIn;
        seenWrite <= 1'b0;
      end
      if (ramWe) begin
        seenWrite <= 1'b1;
        lastAddr  <= ramAddr;
      end
    end
  end

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && !done)); // R2
  AST_KEY_BYTES: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe && ramAddr < 8'd16) |-> (ramWdata == keyCap[8*(15-int'(ramAddr[3:0])) +: 8])); // R3
  AST_ROM_FWD: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !romAddr[8]); // R6
  AST_WR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (ramAddr < 8'd176)); // R7
  AST_WR_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe && seenWrite) |-> (ramAddr == lastAddr + 8'd1)); // R7
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(ramWe) && $past(ramAddr) == 8'd175)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy)); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy); // R9
endmodule

bind keySchedExpand keySchedChecker uChk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .keyIn    (keyIn),
  .busy     (busy),
  .done     (done),
  .romAddr  (romAddr),
  .ramWe    (ramWe),
  .ramAddr  (ramAddr),
  .ramWdata (ramWdata)
);

// File: tb/tb_keySchedExpand.sv
`timescale 1ns/1ps
module tb_keySchedExpand;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [127:0] keyIn = '0;
  logic         busy, done, ramWe;
  logic [8:0]   romAddr;
  logic [7:0]   romData;
  logic [7:0]   ramAddr, ramWdata;

  always #2.5 clk = ~clk;

  keySchedExpand dut (
    .clk(clk), .rstN(rstN), .start(start), .keyIn(keyIn),
    .busy(busy), .done(done), .romAddr(romAddr), .romData(romData),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramWdata(ramWdata)
  );

  int errors = 0;
  int checks = 0;
  logic [7:0] romMem [512];
  logic [7:0] sbox [256];
  logic [7:0] ramMem [176];
  logic [7:0] expSched [176];
  int  wrCount, doneCount, orderErr, romHiCount;
  int  nextAddr;
  logic prevWe;
  logic [7:0] prevAddr;
  int  doneBad;

  always @(posedge clk) romData <= romMem[romAddr];

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1B : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  task automatic buildRom();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 8'h00;
      logic [7:0] s;
      for (int y = 1; y < 256; y++)
        if (x != 0 && gmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      s = inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ 8'h63;
      sbox[x] = s;
      romMem[x] = s;
    end
    for (int x = 0; x < 256; x++) romMem[256 + int'(sbox[x])] = 8'(x);
  endtask

  task automatic buildModel(input logic [127:0] k);
    logic [7:0] rc = 8'h01;
    for (int n = 0; n < 16; n++) expSched[n] = k[8*(15-n) +: 8];
    for (int w = 4; w < 44; w++) begin
      logic [7:0] t [4];
      for (int j = 0; j < 4; j++) t[j] = expSched[4*(w-1) + j];
      if (w % 4 == 0) begin
        logic [7:0] t0 = t[0];
        t[0] = sbox[t[1]] ^ rc;
        t[1] = sbox[t[2]];
        t[2] = sbox[t[3]];
        t[3] = sbox[t0];
        rc = gmul(rc, 8'h02);
      end
      for (int j = 0; j < 4; j++) expSched[4*w + j] = expSched[4*(w-4) + j] ^ t[j];
    end
  endtask

  always @(negedge clk) begin
    if (!rstN) begin
      prevWe <= 1'b0;
    end else begin
      if (ramWe) begin
        ramMem[ramAddr] <= ramWdata;
        wrCount <= wrCount + 1;
        if (int'(ramAddr) != nextAddr) orderErr <= orderErr + 1;
        nextAddr <= int'(ramAddr) + 1;
      end
      if (busy && romAddr[8]) romHiCount <= romHiCount + 1;
      if (done) begin
        doneCount <= doneCount + 1;
        if (!(prevWe && prevAddr == 8'd175)) doneBad <= doneBad + 1;
      end
      prevWe   <= ramWe;
      prevAddr <= ramAddr;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clearMon();
    wrCount = 0; doneCount = 0; orderErr = 0; romHiCount = 0;
    nextAddr = 0; doneBad = 0;
  endtask

  task automatic pulseStart(input logic [127:0] k);
    @(negedge clk);
    keyIn = k;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitIdle(input string req);
    int n = 0;
    while (busy && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(n < 2000, req, "watchdog: run did not finish", n, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic compareSched(input string req, input int lo, input int hi);
    int bad = 0;
    int firstBad = -1;
    for (int n = lo; n <= hi; n++)
      if (ramMem[n] !== expSched[n]) begin
        bad++;
        if (firstBad < 0) firstBad = n;
      end
    if (firstBad < 0) check(1'b1, req, "schedule bytes", 0, 0);
    else check(1'b0, req, $sformatf("schedule byte %0d", firstBad),
               ramMem[firstBad], expSched[firstBad]);
  endtask

  task automatic runCommon(input string tag);
    check(wrCount == 176, "R7", {tag, " write count"}, wrCount, 176);
    check(orderErr == 0, "R7", {tag, " ascending addresses"}, orderErr, 0);
    check(doneCount == 1, "R8", {tag, " done pulse count"}, doneCount, 1);
    check(doneBad == 0, "R8", {tag, " done follows byte 175"}, doneBad, 0);
    check(romHiCount == 0, "R6", {tag, " inverse half untouched"}, romHiCount, 0);
  endtask

  task automatic testReset();
    repeat (4) @(negedge clk);
    check(!busy, "R1", "busy in reset", busy, 0);
    check(!done, "R1", "done in reset", done, 0);
    check(!ramWe, "R1", "ramWe in reset", ramWe, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(!busy && !ramWe && wrCount == 0, "R1", "idle after reset", wrCount, 0);
  endtask

  task automatic testKnownKey();
    logic [127:0] k = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    logic [127:0] lastKey = 128'hd014f9a8c9ee2589e13f0cc8b6630ca6;
    logic [127:0] got;
    clearMon();
    buildModel(k);
    pulseStart(k);
    check(busy, "R2", "busy after accepted start", busy, 1);
    waitIdle("R8");
    compareSched("R3", 0, 15);
    compareSched("R4", 16, 175);
    for (int n = 0; n < 16; n++) got[8*(15-n) +: 8] = ramMem[160 + n];
    check(got == lastKey, "R5", "last round key", got[63:0], lastKey[63:0]);
    runCommon("known key");
  endtask

  task automatic testZeroKey();
    clearMon();
    buildModel('0);
    pulseStart('0);
    waitIdle("R8");
    check({ramMem[16], ramMem[17], ramMem[18], ramMem[19]} == 32'h62636363,
          "R5", "first derived word, zero key",
          {ramMem[16], ramMem[17], ramMem[18], ramMem[19]}, 32'h62636363);
    compareSched("R5", 0, 175);
    runCommon("zero key");
  endtask

  task automatic testOnesKey();
    logic [127:0] k = {128{1'b1}};
    clearMon();
    buildModel(k);
    pulseStart(k);
    waitIdle("R8");
    compareSched("R4", 0, 175);
    runCommon("ones key");
  endtask

  task automatic testStartWhileBusy();
    logic [127:0] k1 = 128'h000102030405060708090a0b0c0d0e0f;
    logic [127:0] k2 = 128'hffeeddccbbaa99887766554433221100;
    clearMon();
    buildModel(k1);
    pulseStart(k1);
    keyIn = k2;
    repeat (40) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R9", "busy held over ignored start", busy, 1);
    waitIdle("R9");
    compareSched("R9", 0, 175);
    compareSched("R3", 0, 15);
    check(wrCount == 176, "R9", "no extra writes", wrCount, 176);
    runCommon("busy start");
  endtask

  initial begin
    clearMon();
    buildRom();
    fork
      begin
        testReset();
        testKnownKey();
        testZeroKey();
        testOnesKey();
        testStartWhileBusy();
      end
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R8", "global watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule